// File: doc/BRIEF.md
# Microcoded Instruction Control Sequencer

This block is the control unit of a small accumulator machine whose registers, memory and ALU all share one bus. On every clock it emits a 16-bit control word. Each bit of that word enables one driver or one load on the bus. The word comes from a microcode table built as synthesizable logic. The table is indexed by a local microstep counter, the 4-bit opcode held in the instruction register, and the latched zero and carry flags.

Every instruction starts with the same two fetch steps and then runs its own execute steps. The flags are part of the table index, so a conditional jump takes its branch or falls through inside the microcode itself, with no separate branch logic. The sequencer looks one entry ahead. When the next entry is empty, the counter goes back to step 0 on the following clock, so short instructions spend no idle cycles.

Once a word with the halt bit has been issued, the sequencer freezes. The counter stops and the halt word is held until reset, whatever the opcode and flag inputs do. No data stream crosses this boundary: every pin is a plain control or status signal with no valid/ready handshake.

Top module: `ucode_sequencer`

## Requirements
- R1: While reset is asserted and on the first cycle after it is released, the step counter is 0 and `ctrl_word` equals the first fetch word 0x4004 (counter-out on bit 2, address-register-load on bit 14).
- R2: Step 1 of every instruction outputs 0x1408: RAM-out on bit 12, instruction-register-load on bit 10, counter-increment on bit 3.
- R3: The control bits are: halt 15, address-register-load 14, RAM-load 13, RAM-out 12, operand-out 11, instruction-register-load 10, accumulator-load 9, accumulator-out 8, ALU-out 7, subtract 6, B-load 5, display-load 4, counter-increment 3, counter-out 2, jump 1. Bit 0 is always 0.
- R4: The table index is {carry, zero, opcode[3:0], step[3:0]}, with carry as the MSB. On the flag input, `flags[0]` is carry and `flags[1]` is zero.
- R5: Load-from-memory (opcode 1) executes 0x4800 then 0x1200. Store (opcode 4) executes 0x4800 then 0x2100. Load-immediate (opcode 5) executes 0x0A00.
- R6: Add (opcode 2) executes 0x4800, 0x1020, 0x0280. Subtract (opcode 3) is the same except that its last step is 0x02C0, with the subtract bit set.
- R7: Unconditional jump (opcode 6) executes 0x0802, which drives the operand onto the bus and asserts jump.
- R8: Jump-if-zero (opcode 7) executes 0x0802 only when zero is 1, and jump-if-carry (opcode 8) does so only when carry is 1. Otherwise each ends after fetch, like a no-op.
- R9: Output (opcode 14) executes 0x0110.
- R10: Opcode 0 and the unassigned opcodes 9 to 13 run only the two fetch steps. Every unused table entry outputs 0.
- R11: After the last non-zero step of an instruction, the counter returns to 0 on the next clock, so fetch step 0 follows at once.
- R12: Halt (opcode 15) outputs 0x8000 at step 2. From then on `ctrl_word` stays 0x8000 and any change on `opcode` or `flags` has no effect until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| opcode | input | 4 | Opcode from the instruction register |
| flags | input | 2 | Latched flags: bit 0 carry, bit 1 zero |
| ctrl_word | output | 16 | Control word for the current microstep |

## Verification
The bench runs every opcode, 0 to 15, under all four flag combinations. This separates flag-sensitive entries from those that ignore the flags, and it exposes any swap of the zero and carry positions in the index. Each run continues past the instruction's end into the next fetch, which shows both the exact end step and the return to step 0. The halt run then toggles the opcode and flags while frozen to show they are ignored, and a final reset shows that it releases the freeze.

// File: rtl/ucode_pkg.sv
package ucode_pkg;
  localparam int STEP_W = 4;
  localparam int OP_W   = 4;
  localparam int CW_W   = 16;
  localparam int ADDR_W = STEP_W + OP_W + 2;

  // control bit positions
  localparam int B_HLT = 15;
  localparam int B_MI  = 14;
  localparam int B_RI  = 13;
  localparam int B_RO  = 12;
  localparam int B_IO  = 11;
  localparam int B_II  = 10;
  localparam int B_AI  = 9;
  localparam int B_AO  = 8;
  localparam int B_EO  = 7;
  localparam int B_SU  = 6;
  localparam int B_BI  = 5;
  localparam int B_OI  = 4;
  localparam int B_CE  = 3;
  localparam int B_CO  = 2;
  localparam int B_J   = 1;

  typedef logic [CW_W-1:0] cw_t;

  typedef enum logic [OP_W-1:0] {
    OP_NOP = 4'd0,  OP_LDA = 4'd1, OP_ADD = 4'd2, OP_SUB = 4'd3,
    OP_STA = 4'd4,  OP_LDI = 4'd5, OP_JMP = 4'd6, OP_JZ  = 4'd7,
    OP_JC  = 4'd8,  OP_OUT = 4'd14, OP_HLT = 4'd15
  } opcode_e;

  function automatic cw_t bit_of(input int pos);
    cw_t w;
    w = '0;
    w[pos] = 1'b1;
    return w;
  endfunction
endpackage

// File: rtl/ucode_rom.sv
module ucode_rom
  import ucode_pkg::*;
(
  input  logic [ADDR_W-1:0] addr,
  output cw_t               word
);
  logic [STEP_W-1:0] step;
  logic [OP_W-1:0]   op;
  logic              zf;
  logic              cf;
  cw_t               fetch0, fetch1, mar_op, alu_to_a;

  assign step = addr[STEP_W-1:0];
  assign op   = addr[STEP_W +: OP_W];
  assign zf   = addr[STEP_W+OP_W];
  assign cf   = addr[STEP_W+OP_W+1];

  assign fetch0   = bit_of(B_CO) | bit_of(B_MI);
  assign fetch1   = bit_of(B_RO) | bit_of(B_II) | bit_of(B_CE);
  assign mar_op   = bit_of(B_IO) | bit_of(B_MI);
  assign alu_to_a = bit_of(B_EO) | bit_of(B_AI);

  always_comb begin
    word = '0;
    if (step == 4'd0) begin
      word = fetch0;
    end else if (step == 4'd1) begin
      word = fetch1;
    end else begin
      case (op)
        OP_LDA: case (step)
          4'd2:    word = mar_op;
          4'd3:    word = bit_of(B_RO) | bit_of(B_AI);
          default: word = '0;
        endcase
        OP_ADD, OP_SUB: case (step)
          4'd2:    word = mar_op;
          4'd3:    word = bit_of(B_RO) | bit_of(B_BI);
          4'd4:    word = (op == OP_SUB) ? (alu_to_a | bit_of(B_SU)) : alu_to_a;
          default: word = '0;
        endcase
        OP_STA: case (step)
          4'd2:    word = mar_op;
          4'd3:    word = bit_of(B_AO) | bit_of(B_RI);
          default: word = '0;
        endcase
        OP_LDI: word = (step == 4'd2) ? (bit_of(B_IO) | bit_of(B_AI)) : '0;
        OP_JMP: word = (step == 4'd2) ? (bit_of(B_IO) | bit_of(B_J)) : '0;
        OP_JZ:  word = (step == 4'd2 && zf) ? (bit_of(B_IO) | bit_of(B_J)) : '0;
        OP_JC:  word = (step == 4'd2 && cf) ? (bit_of(B_IO) | bit_of(B_J)) : '0;
        OP_OUT: word = (step == 4'd2) ? (bit_of(B_AO) | bit_of(B_OI)) : '0;
        OP_HLT: word = (step == 4'd2) ? bit_of(B_HLT) : '0;
        default: word = '0;
      endcase
    end
  end
endmodule

// File: rtl/ustep_counter.sv
module ustep_counter
  import ucode_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              freeze,
  input  logic              wrap,
  output logic [STEP_W-1:0] step
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      step <= '0;
    else if (freeze) step <= step;
    else if (wrap)   step <= '0;
    else             step <= step + 1'b1;
  end
endmodule

// File: rtl/halt_latch.sv
module halt_latch
  import ucode_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  cw_t  word_in,
  output logic halted,
  output cw_t  held_word
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      halted    <= 1'b0;
      held_word <= '0;
    end else if (!halted && word_in[B_HLT]) begin
      halted    <= 1'b1;
      held_word <= word_in;
    end
  end
endmodule

// File: rtl/ucode_sequencer.sv
module ucode_sequencer
  import ucode_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic [3:0]  opcode,
  input  logic [1:0]  flags,
  output logic [15:0] ctrl_word
);
  logic [STEP_W-1:0] step;
  logic [STEP_W-1:0] step_at [2];
  logic [ADDR_W-1:0] rom_addr [2];
  cw_t               rom_word [2];
  cw_t               held_word;
  logic              halted;
  logic              freeze;
  logic              wrap;

  assign step_at[0] = step;
  assign step_at[1] = step + 1'b1;

  // port 0 reads the current step, port 1 looks one step ahead
  for (genvar g = 0; g < 2; g++) begin : g_port
    assign rom_addr[g] = {flags[0], flags[1], opcode, step_at[g]};
    ucode_rom u_rom (.addr(rom_addr[g]), .word(rom_word[g]));
  end

  assign freeze = halted | rom_word[0][B_HLT];
  assign wrap   = (rom_word[1] == '0);

  ustep_counter u_cnt (
    .clk(clk), .rst_n(rst_n), .freeze(freeze), .wrap(wrap), .step(step)
  );

  halt_latch u_halt (
    .clk(clk), .rst_n(rst_n), .word_in(rom_word[0]),
    .halted(halted), .held_word(held_word)
  );

  assign ctrl_word = halted ? held_word : rom_word[0];
endmodule

// File: rtl/ucode_sequencer_chk.sv
module ucode_sequencer_chk
  import ucode_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic [15:0]       ctrl_word,
  input logic [STEP_W-1:0] step,
  input logic              halted,
  input logic              wrap
);
  // R1
  step0_fetch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step == '0 && !halted) |-> ctrl_word == 16'h4004);
  // R2
  step1_fetch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step == 4'd1 && !halted) |-> ctrl_word == 16'h1408);
  // R3
  spare_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_word[0] == 1'b0);
  // R11
  wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl_word[15] && wrap) |=> step == '0);
  // R11
  advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl_word[15] && !wrap) |=> step == $past(step) + 1'b1);
  // R12
  halt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_word[15] |=> ($stable(ctrl_word) && $stable(step)));
endmodule

bind ucode_sequencer ucode_sequencer_chk u_chk (
  .clk(clk), .rst_n(rst_n), .ctrl_word(ctrl_word),
  .step(step), .halted(halted), .wrap(wrap)
);

// File: tb/ucode_sequencer_tb.sv
module ucode_sequencer_tb;
  localparam int PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  opcode = '0;
  logic [1:0]  flags = '0;
  logic [15:0] ctrl_word;
  int checks = 0;
  int errors = 0;

  always #(PERIOD/2) clk = ~clk;

  ucode_sequencer u_dut (
    .clk(clk), .rst_n(rst_n), .opcode(opcode), .flags(flags), .ctrl_word(ctrl_word)
  );

  // execute-phase word list per opcode, built from bit positions of R3
  function automatic int exec_len(input int op, input int fl);
    case (op)
      1, 4:    return 2;
      2, 3:    return 3;
      5, 6, 14, 15: return 1;
      7:       return fl[1] ? 1 : 0;
      8:       return fl[0] ? 1 : 0;
      default: return 0;
    endcase
  endfunction

  function automatic logic [15:0] exec_word(input int op, input int k);
    logic [15:0] mar = (16'd1 << 11) + (16'd1 << 14);
    case (op)
      1: return (k == 0) ? mar : (16'd1 << 12) + (16'd1 << 9);
      4: return (k == 0) ? mar : (16'd1 << 8) + (16'd1 << 13);
      2, 3: begin
        if (k == 0) return mar;
        if (k == 1) return (16'd1 << 12) + (16'd1 << 5);
        return (16'd1 << 7) + (16'd1 << 9) + ((op == 3) ? (16'd1 << 6) : 16'd0);
      end
      5: return (16'd1 << 11) + (16'd1 << 9);
      6, 7, 8: return (16'd1 << 11) + (16'd1 << 1);
      14: return (16'd1 << 8) + (16'd1 << 4);
      15: return 16'd1 << 15;
      default: return 16'd0;
    endcase
  endfunction

  function automatic logic [15:0] exp_at(input int op, input int fl, input int i);
    int n = 2 + exec_len(op, fl);
    int s = i % n;
    if (s == 0) return 16'h4004;
    if (s == 1) return 16'h1408;
    return exec_word(op, s - 2);
  endfunction

  function automatic string req_of(input int op, input int s);
    if (s == 0) return "R1";
    if (s == 1) return "R2";
    case (op)
      1, 4, 5: return "R5";
      2, 3:    return "R6";
      6:       return "R7";
      7, 8:    return "R8";
      14:      return "R9";
      15:      return "R12";
      default: return "R10";
    endcase
  endfunction

  task automatic check(input string req, input logic [15:0] got, input logic [15:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s op=%0d flags=%0d got=%h exp=%h", req, opcode, flags, got, exp);
    end
  endtask

  task automatic do_reset(input int op, input int fl);
    @(negedge clk);
    rst_n  = 1'b0;
    opcode = 4'(op);
    flags  = 2'(fl);
    @(negedge clk);
    check("R1", ctrl_word, 16'h4004);
    rst_n = 1'b1;
  endtask

  initial begin
    #(PERIOD * 150000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    // sweep all non-halting opcodes under all flag values (R4, R11)
    for (int op = 0; op < 15; op++) begin
      for (int fl = 0; fl < 4; fl++) begin
        int n;
        do_reset(op, fl);
        n = 2 + exec_len(op, fl);
        for (int i = 0; i < n + 3; i++) begin
          // R4 R11: index uses both flags; wrap back to fetch after last step
          check((i >= n) ? "R11" : req_of(op, i % n), ctrl_word, exp_at(op, fl, i));
          check("R3", {15'd0, ctrl_word[0]}, 16'd0);
          @(negedge clk);
        end
      end
    end

    // halt: freeze and ignore inputs (R12)
    for (int fl = 0; fl < 4; fl++) begin
      do_reset(15, fl);
      for (int i = 0; i < 3; i++) begin
        check(req_of(15, i), ctrl_word, exp_at(15, fl, i));
        @(negedge clk);
      end
      for (int i = 0; i < 6; i++) begin
        opcode = 4'(i + 1);
        flags  = 2'(i);
        #1;
        check("R12", ctrl_word, 16'h8000);
        @(negedge clk);
        check("R12", ctrl_word, 16'h8000);
      end
    end
    // R1: reset releases the halt
    do_reset(2, 0);
    check("R1", ctrl_word, 16'h4004);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule